// File: doc/BRIEF.md
# Credit-Gated Round-Robin Egress Cell Scheduler

This block is the transmit half of one port in a shared-memory cell switch. It watches every arrival event that the ingress ports announce. Each event carries a circuit number and the cell's slot address in common memory. A local circuit table says whether the circuit exits through this port and, if it does, which local virtual-channel (VC) queue holds it. Matching cells have their circuit number and address pushed into that VC's FIFO. Other cells are ignored.

On every cycle with `slot_en` high, the block offers one cell slot. It searches the VCs in round-robin order, starting from a rotating pointer. A VC may win only if its FIFO is not empty and it holds at least one credit from the next hop downstream. The winner's head cell is popped, and one credit is spent. The cell's circuit number, address and VC appear on the departure bus for one cycle, so that the rest of the switch can release the memory and count departures. Credit cells that return from downstream add a given amount to a VC's balance.

A two-state machine paces the departure bus. `SCH_IDLE` drives no event. `SCH_ISSUE` presents a departure. The transition into `SCH_ISSUE` (take a cell) happens on a slot that finds an eligible VC. The transition into `SCH_IDLE` (nothing sent) happens on any cycle without a winning slot. `SCH_ISSUE` may follow itself when slots are back to back.

Top module: `vc_credit_sched`

## Requirements
- R1: After reset all FIFOs are empty, every credit balance is 0, the round-robin pointer is at VC 0, every table entry is non-matching, and `dep_valid` is 0.
- R2: A cycle with `cfg_we` high writes the match bit and the VC index for `cfg_cid`. The new entry is used for arrivals in later cycles only. An arrival (`arr_valid`) is enqueued only when its circuit's match bit is 1, and it goes into the VC named by the table.
- R3: Each VC FIFO is first in, first out and holds `FIFO_DEPTH` cells. An arrival is discarded if its FIFO already holds `FIFO_DEPTH` cells at the start of the cycle, even when that FIFO is popped in the same cycle.
- R4: A VC is eligible in a slot only if its FIFO holds a cell and its credit balance is at least 1, both as they stand at the start of the cycle. A cell that arrives in a cycle cannot depart in that same cycle.
- R5: The search starts at the pointer and moves upward through the VCs, wrapping around. After VC v is served, the pointer becomes (v+1) mod `NUM_VC`.
- R6: A slot with no eligible VC produces no departure and leaves the pointer unchanged.
- R7: When a slot is granted in cycle t, `dep_valid` is 1 in cycle t+1 for exactly one cycle. In that cycle `dep_cid`, `dep_addr` and `dep_vc` carry the served cell's circuit number, its address and its VC.
- R8: Each departure takes one credit from its VC. A credit event adds `cred_amt` to `cred_vc`. A credit event and a departure on the same VC in the same cycle both take effect. The balance saturates at 2^`CRED_W`-1.
- R9: Each slot yields at most one departure. No departure occurs in a cycle after `slot_en` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Circuit table write strobe |
| cfg_cid | input | CID_W | Circuit number to write |
| cfg_match | input | 1 | 1 = circuit exits through this port |
| cfg_vc | input | VC_W | Local VC queue for the circuit |
| arr_valid | input | 1 | Arrival event on the shared bus |
| arr_cid | input | CID_W | Circuit number of the arriving cell |
| arr_addr | input | ADDR_W | Common-memory address of the arriving cell |
| cred_valid | input | 1 | Credit return event |
| cred_vc | input | VC_W | VC that receives the credits |
| cred_amt | input | CRED_W | Number of credits returned |
| slot_en | input | 1 | One transmit slot is offered this cycle |
| dep_valid | output | 1 | Departure event |
| dep_cid | output | CID_W | Circuit number of the departing cell |
| dep_addr | output | ADDR_W | Address of the departing cell |
| dep_vc | output | VC_W | VC of the departing cell |

## Verification
The hardest cases to reach from the ports combine three things in one cycle: a full FIFO, a saturated credit balance, and a send on the same VC as a credit return or an arrival. These need the queue and the credit count to be driven to their limits first, while no slot drains them. Directed phases do that setup. They fill the table, load the queues while credit is still zero, and then release credit one VC at a time. A long pseudo-random phase follows, with every input live. Throughout, a cycle-accurate model in the bench predicts every departure-bus value.

// File: rtl/vc_credit_sched_pkg.sv
package vc_credit_sched_pkg;

    typedef enum logic {
        SCH_IDLE  = 1'b0,
        SCH_ISSUE = 1'b1
    } sch_state_e;

endpackage

// File: rtl/vc_fifo.sv
module vc_fifo #(
    parameter int ENT_W = 12,
    parameter int DEPTH = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [ENT_W-1:0] wdata,
    input  logic             pop,
    output logic [ENT_W-1:0] rdata,
    output logic [CNT_W-1:0] count
);

    logic [ENT_W-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             do_push;

    assign do_push = push && (count != CNT_W'(DEPTH));
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= wdata;
                wr_ptr      <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            count <= count + CNT_W'(do_push) - CNT_W'(pop);
        end
    end

endmodule

// File: rtl/credit_counter.sv
module credit_counter #(
    parameter int CRED_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add_en,
    input  logic [CRED_W-1:0] add_amt,
    input  logic              take,
    output logic [CRED_W-1:0] bal
);

    localparam logic [CRED_W:0] MAX_BAL = (CRED_W + 1)'((1 << CRED_W) - 1);

    logic [CRED_W:0] sum;

    always_comb begin
        sum = {1'b0, bal}
            + (add_en ? {1'b0, add_amt} : '0)
            - {{CRED_W{1'b0}}, take};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bal <= '0;
        end else begin
            bal <= (sum > MAX_BAL) ? MAX_BAL[CRED_W-1:0] : sum[CRED_W-1:0];
        end
    end

endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N = 4,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    input  logic [W-1:0] ptr,
    output logic         gnt_any,
    output logic [W-1:0] gnt_idx
);

    int idx;

    always_comb begin
        gnt_any = 1'b0;
        gnt_idx = '0;
        idx     = 0;
        for (int i = 0; i < N; i++) begin
            idx = (int'(ptr) + i) % N;
            if (!gnt_any && req[idx]) begin
                gnt_any = 1'b1;
                gnt_idx = W'(idx);
            end
        end
    end

endmodule

// File: rtl/vc_credit_sched.sv
module vc_credit_sched
    import vc_credit_sched_pkg::*;
#(
    parameter int NUM_VC     = 4,
    parameter int CID_W      = 4,
    parameter int ADDR_W     = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int CRED_W     = 3,
    localparam int VC_W    = $clog2(NUM_VC),
    localparam int NUM_CID = 1 << CID_W,
    localparam int ENT_W   = CID_W + ADDR_W,
    localparam int CNT_W   = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CID_W-1:0]  cfg_cid,
    input  logic              cfg_match,
    input  logic [VC_W-1:0]   cfg_vc,
    input  logic              arr_valid,
    input  logic [CID_W-1:0]  arr_cid,
    input  logic [ADDR_W-1:0] arr_addr,
    input  logic              cred_valid,
    input  logic [VC_W-1:0]   cred_vc,
    input  logic [CRED_W-1:0] cred_amt,
    input  logic              slot_en,
    output logic              dep_valid,
    output logic [CID_W-1:0]  dep_cid,
    output logic [ADDR_W-1:0] dep_addr,
    output logic [VC_W-1:0]   dep_vc
);

    // circuit table
    logic            tbl_match [NUM_CID];
    logic [VC_W-1:0] tbl_vc    [NUM_CID];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CID; c++) begin
                tbl_match[c] <= 1'b0;
                tbl_vc[c]    <= '0;
            end
        end else if (cfg_we) begin
            tbl_match[cfg_cid] <= cfg_match;
            tbl_vc[cfg_cid]    <= cfg_vc;
        end
    end

    // per-VC queues and credits
    logic [NUM_VC-1:0][CNT_W-1:0]  q_cnt;
    logic [NUM_VC-1:0][ENT_W-1:0]  q_head;
    logic [NUM_VC-1:0][CRED_W-1:0] cred_bal;
    logic [NUM_VC-1:0]             elig;
    logic [NUM_VC-1:0]             q_push;
    logic [NUM_VC-1:0]             q_pop;
    logic [VC_W-1:0]               rr_ptr;
    logic                          gnt_any;
    logic [VC_W-1:0]               gnt_idx;
    logic                          take_cell;

    assign take_cell = slot_en && gnt_any;

    for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
        assign q_push[v] = arr_valid && tbl_match[arr_cid]
                           && (tbl_vc[arr_cid] == VC_W'(v));
        assign q_pop[v]  = take_cell && (gnt_idx == VC_W'(v));
        assign elig[v]   = (q_cnt[v] != '0) && (cred_bal[v] != '0);

        vc_fifo #(
            .ENT_W (ENT_W),
            .DEPTH (FIFO_DEPTH)
        ) fifo_i (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (q_push[v]),
            .wdata ({arr_cid, arr_addr}),
            .pop   (q_pop[v]),
            .rdata (q_head[v]),
            .count (q_cnt[v])
        );

        credit_counter #(
            .CRED_W (CRED_W)
        ) cred_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .add_en  (cred_valid && (cred_vc == VC_W'(v))),
            .add_amt (cred_amt),
            .take    (q_pop[v]),
            .bal     (cred_bal[v])
        );
    end

    rr_pick #(
        .N (NUM_VC)
    ) pick_i (
        .req     (elig),
        .ptr     (rr_ptr),
        .gnt_any (gnt_any),
        .gnt_idx (gnt_idx)
    );

    // FSM: state register
    sch_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SCH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            SCH_IDLE:  state_d = take_cell ? SCH_ISSUE : SCH_IDLE;
            SCH_ISSUE: state_d = take_cell ? SCH_ISSUE : SCH_IDLE;
            default:   state_d = SCH_IDLE;
        endcase
    end

    // pointer and departure payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr   <= '0;
            dep_cid  <= '0;
            dep_addr <= '0;
            dep_vc   <= '0;
        end else if (take_cell) begin
            rr_ptr   <= (gnt_idx == VC_W'(NUM_VC - 1)) ? '0 : gnt_idx + 1'b1;
            dep_cid  <= q_head[gnt_idx][ENT_W-1:ADDR_W];
            dep_addr <= q_head[gnt_idx][ADDR_W-1:0];
            dep_vc   <= gnt_idx;
        end
    end

    // FSM: outputs
    always_comb begin
        unique case (state_q)
            SCH_ISSUE: dep_valid = 1'b1;
            default:   dep_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/vc_credit_sched_chk.sv
module vc_credit_sched_chk #(
    parameter int NUM_VC     = 4,
    parameter int FIFO_DEPTH = 4,
    parameter int CRED_W     = 3,
    localparam int VC_W  = $clog2(NUM_VC),
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             slot_en,
    input logic                             dep_valid,
    input logic [VC_W-1:0]                  dep_vc,
    input logic [VC_W-1:0]                  rr_ptr,
    input logic [NUM_VC-1:0]                elig,
    input logic [NUM_VC-1:0][CRED_W-1:0]    cred_bal,
    input logic [NUM_VC-1:0][CNT_W-1:0]     q_cnt
);

    logic [NUM_VC-1:0][CRED_W-1:0] prev_bal;
    logic [NUM_VC-1:0][CNT_W-1:0]  prev_cnt;
    logic [VC_W-1:0]               ptr_after;

    always_ff @(posedge clk) begin
        prev_bal <= cred_bal;
        prev_cnt <= q_cnt;
    end

    assign ptr_after = (dep_vc == VC_W'(NUM_VC - 1)) ? '0 : dep_vc + 1'b1;

    assert_dep_after_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dep_valid |-> $past(slot_en));

    assert_slot_issues_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_en && elig != '0) |=> dep_valid);

    assert_dep_had_credit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dep_valid |-> (prev_bal[dep_vc] != '0) && (prev_cnt[dep_vc] != '0));

    assert_idle_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_en && elig == '0) |=> $stable(rr_ptr));

    assert_ptr_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dep_valid |-> rr_ptr == ptr_after);

    for (genvar v = 0; v < NUM_VC; v++) begin : g_chk
        assert_fifo_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
            q_cnt[v] <= CNT_W'(FIFO_DEPTH));
    end

endmodule

bind vc_credit_sched vc_credit_sched_chk #(
    .NUM_VC     (NUM_VC),
    .FIFO_DEPTH (FIFO_DEPTH),
    .CRED_W     (CRED_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_en   (slot_en),
    .dep_valid (dep_valid),
    .dep_vc    (dep_vc),
    .rr_ptr    (rr_ptr),
    .elig      (elig),
    .cred_bal  (cred_bal),
    .q_cnt     (q_cnt)
);

// File: tb/vc_credit_sched_tb_top.sv
`timescale 1ns/1ps
module vc_credit_sched_tb_top;

    localparam int NV = 4;
    localparam int CW = 4;
    localparam int AW = 8;
    localparam int QD = 4;
    localparam int KW = 3;
    localparam int KMAX = 7;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we, cfg_match;
    logic [CW-1:0] cfg_cid, arr_cid;
    logic [1:0]    cfg_vc, cred_vc;
    logic          arr_valid, cred_valid, slot_en;
    logic [AW-1:0] arr_addr;
    logic [KW-1:0] cred_amt;
    logic          dep_valid;
    logic [CW-1:0] dep_cid;
    logic [AW-1:0] dep_addr;
    logic [1:0]    dep_vc;

    always #2.5 clk = ~clk;

    vc_credit_sched dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_cid(cfg_cid), .cfg_match(cfg_match), .cfg_vc(cfg_vc),
        .arr_valid(arr_valid), .arr_cid(arr_cid), .arr_addr(arr_addr),
        .cred_valid(cred_valid), .cred_vc(cred_vc), .cred_amt(cred_amt),
        .slot_en(slot_en),
        .dep_valid(dep_valid), .dep_cid(dep_cid), .dep_addr(dep_addr), .dep_vc(dep_vc)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // reference model state
    int m_match [16];
    int m_vc    [16];
    int mq      [NV][QD];
    int mq_head [NV];
    int mq_cnt  [NV];
    int m_cred  [NV];
    int m_ptr;
    int e_valid, e_cid, e_addr, e_vc;

    task automatic idle_inputs();
        cfg_we = 0; cfg_cid = 0; cfg_match = 0; cfg_vc = 0;
        arr_valid = 0; arr_cid = 0; arr_addr = 0;
        cred_valid = 0; cred_vc = 0; cred_amt = 0;
        slot_en = 0;
    endtask

    task automatic model_step();
        int pre_cnt [NV];
        int g;
        g = -1;
        for (int v = 0; v < NV; v++) pre_cnt[v] = mq_cnt[v];
        if (slot_en) begin
            for (int i = 0; i < NV; i++) begin
                int v;
                v = (m_ptr + i) % NV;
                if (g < 0 && mq_cnt[v] > 0 && m_cred[v] > 0) g = v;
            end
        end
        e_valid = (g >= 0);
        if (g >= 0) begin
            int ent;
            ent = mq[g][mq_head[g]];
            e_cid  = ent / 256;
            e_addr = ent % 256;
            e_vc   = g;
            mq_head[g] = (mq_head[g] + 1) % QD;
            mq_cnt[g]--;
            m_ptr = (g + 1) % NV;
        end
        for (int v = 0; v < NV; v++) begin
            int c;
            c = m_cred[v];
            if (cred_valid && int'(cred_vc) == v) c += int'(cred_amt);
            if (g == v) c -= 1;
            m_cred[v] = (c > KMAX) ? KMAX : c;
        end
        if (arr_valid && m_match[arr_cid] != 0) begin
            int t;
            t = m_vc[arr_cid];
            if (pre_cnt[t] < QD) begin
                mq[t][(mq_head[t] + mq_cnt[t]) % QD] = int'(arr_cid) * 256 + int'(arr_addr);
                mq_cnt[t]++;
            end
        end
        if (cfg_we) begin
            m_match[cfg_cid] = cfg_match;
            m_vc[cfg_cid]    = cfg_vc;
        end
    endtask

    task automatic compare(string tag);
        n_checks++;
        if (dep_valid !== 1'(e_valid)) begin
            n_fail++;
            $display("FAIL %s dep_valid actual %0b expected %0d", tag, dep_valid, e_valid);
        end else if (e_valid != 0) begin
            n_checks++;
            if (int'(dep_cid) != e_cid || int'(dep_addr) != e_addr || int'(dep_vc) != e_vc) begin
                n_fail++;
                $display("FAIL %s departure actual cid=%0d addr=%0d vc=%0d expected cid=%0d addr=%0d vc=%0d",
                         tag, dep_cid, dep_addr, dep_vc, e_cid, e_addr, e_vc);
            end
        end
    endtask

    // inputs are set at a negedge; one clock edge is applied and the result checked
    task automatic step(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
        idle_inputs();
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL ALL watchdog expired actual running expected finished");
        finish_run();
    end

    logic [15:0] lfsr = 16'hACE1;
    function automatic logic [15:0] lfsr_next(logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    initial begin
        idle_inputs();
        rst_n = 0;
        for (int c = 0; c < 16; c++) begin m_match[c] = 0; m_vc[c] = 0; end
        for (int v = 0; v < NV; v++) begin mq_head[v] = 0; mq_cnt[v] = 0; m_cred[v] = 0; end
        m_ptr = 0; e_valid = 0; e_cid = 0; e_addr = 0; e_vc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        compare("R1 reset");

        // R2: table sweep over every circuit
        for (int c = 0; c < 16; c++) begin
            cfg_we = 1; cfg_cid = CW'(c); cfg_match = (c % 3 != 0); cfg_vc = 2'(c % 4);
            step("R2 cfg");
        end
        // arrivals on every circuit, slots offered but no credit yet (R1, R4)
        for (int c = 0; c < 16; c++) begin
            arr_valid = 1; arr_cid = CW'(c); arr_addr = AW'(c * 3 + 1); slot_en = 1;
            step("R2 R4 arrive no credit");
        end
        // one credit per VC, then slots: order follows the pointer (R5, R7)
        for (int v = 0; v < NV; v++) begin
            cred_valid = 1; cred_vc = 2'(v); cred_amt = 1;
            step("R8 credit load");
        end
        for (int k = 0; k < 4; k++) begin slot_en = 1; step("R5 R7 rotation"); end
        // R6: no credit left anywhere
        for (int k = 0; k < 3; k++) begin slot_en = 1; step("R6 idle slot"); end
        // R5: pointer is at VC 0 but only VC 1 is eligible
        cred_valid = 1; cred_vc = 1; cred_amt = 1; step("R8 credit");
        slot_en = 1; step("R5 skip to eligible");
        // R8: credit and send on the same VC in the same cycle
        cred_valid = 1; cred_vc = 2; cred_amt = 1; step("R8 credit");
        slot_en = 1; cred_valid = 1; cred_vc = 2; cred_amt = 1; step("R8 net credit");
        slot_en = 1; step("R8 net credit follow");
        slot_en = 1; step("R8 net credit drained");
        // R8: saturation, 7 + 7 kept as 7, then feed VC 0 through circuit 4
        cred_valid = 1; cred_vc = 0; cred_amt = 7; step("R8 sat load");
        cred_valid = 1; cred_vc = 0; cred_amt = 7; step("R8 sat load");
        for (int k = 0; k < 24; k++) begin
            arr_valid = 1; arr_cid = 4; arr_addr = AW'(100 + k); slot_en = (k % 2 == 1);
            step("R8 saturation");
        end
        for (int k = 0; k < 6; k++) begin slot_en = 1; step("R8 saturation drain"); end
        // R3: overflow of VC 1 through circuit 13, then drain in order
        for (int k = 0; k < 6; k++) begin
            arr_valid = 1; arr_cid = 13; arr_addr = AW'(200 + k);
            step("R3 fill");
        end
        cred_valid = 1; cred_vc = 1; cred_amt = 7; step("R3 credit");
        for (int k = 0; k < 8; k++) begin slot_en = 1; step("R3 drain order"); end
        // R2: write and arrival in the same cycle use the old entry
        cfg_we = 1; cfg_cid = 0; cfg_match = 1; cfg_vc = 3;
        arr_valid = 1; arr_cid = 0; arr_addr = 8'h55; step("R2 same-cycle cfg");
        arr_valid = 1; arr_cid = 0; arr_addr = 8'h66; step("R2 new entry");
        cred_valid = 1; cred_vc = 3; cred_amt = 3; step("R2 credit");
        // R9: credit and cells present but no slot
        for (int k = 0; k < 3; k++) step("R9 no slot");
        for (int k = 0; k < 3; k++) begin slot_en = 1; step("R2 R9 drain"); end
        // R4: arrival with credit and slot in the same cycle is not sent yet
        arr_valid = 1; arr_cid = 7; arr_addr = 8'h77; slot_en = 1;
        cred_valid = 1; cred_vc = 3; cred_amt = 1;
        step("R4 same-cycle arrival");
        slot_en = 1; step("R4 next slot");

        // mixed pseudo-random traffic
        for (int k = 0; k < 4000; k++) begin
            lfsr = lfsr_next(lfsr); lfsr = lfsr_next(lfsr);
            arr_valid  = lfsr[0] | lfsr[1];
            arr_cid    = lfsr[5:2];
            arr_addr   = lfsr[13:6];
            lfsr = lfsr_next(lfsr); lfsr = lfsr_next(lfsr); lfsr = lfsr_next(lfsr);
            cred_valid = lfsr[0] & lfsr[1];
            cred_vc    = lfsr[3:2];
            cred_amt   = lfsr[6:4];
            slot_en    = lfsr[7] | lfsr[8];
            cfg_we     = (lfsr[15:10] == 6'h2A);
            cfg_cid    = lfsr[12:9];
            cfg_match  = lfsr[13];
            cfg_vc     = lfsr[15:14];
            step("R3 R4 R5 R6 R7 R8 mixed");
        end
        finish_run();
    end

endmodule